// File: doc/BRIEF.md
# Reconfigurable-Associativity Cache Tag Directory

This block is the tag side of a small cache. It has eight block frames that can be grouped at run time into eight direct-mapped sets, four 2-way sets, two 4-way sets or one fully associative set. Each cycle it can take one block-address access with a read/write flag. One cycle later it reports hit or miss. On a miss it also reports why the miss happened: first touch, capacity or conflict. It uses least-recently-used replacement inside each set. Depending on the write policy, it sends write-through or dirty-eviction request pulses toward the next memory level.

The miss category comes from two side structures that see the same access stream. One is a per-address "seen" flag over the whole 64-block address space. The other is a shadow eight-frame fully associative LRU directory. The block also keeps a running access count and a running hit count. The configuration is sampled every cycle. A change in either geometry or write policy takes one cycle: in that cycle new accesses are refused, both counters clear and every frame is invalidated.

Top module: `cache_tag_dir`

## Requirements
- R1: `cfg_ways` code c (0, 1, 2, 3) selects 2^c ways per set and 8 >> c sets. An access maps to set `acc_addr mod sets`, and a hit needs the same full block address to be resident in that set.
- R2: When a set is full, a miss replaces that set's least recently used frame. Hits and fills both make the accessed frame the most recently used.
- R3: An access is accepted in a cycle where `acc_valid` and `acc_ready` are both high. `rsp_valid` is high in the next cycle and only then, with `rsp_hit` set on a hit. Accesses may be accepted on back-to-back cycles.
- R4: `rsp_kind` is 0 on a hit. It is 1 (compulsory) on a miss whose block address has not been accepted since reset.
- R5: On any other miss, `rsp_kind` is 2 (capacity) when an eight-frame fully associative LRU directory fed the same stream also misses, and 3 (conflict) otherwise.
- R6: With `cfg_wb`=1 (write-back), a write marks its frame dirty and causes no request by itself. Replacing a dirty frame pulses `low_req` with `low_req_evict`=1 and `low_req_addr` set to the victim's block address. Replacing a clean frame sends no request.
- R7: With `cfg_wb`=0 (write-through), every accepted write pulses `low_req` with `low_req_evict`=0 and `low_req_addr` equal to the written address. Reads and evictions send no request.
- R8: `cnt_access` counts accepted accesses and `cnt_hit` counts hits. Both are 16 bits wide and hold at all ones instead of wrapping.
- R9: In a cycle where {`cfg_ways`,`cfg_wb`} differs from the value in effect, `acc_ready` is low. At the next edge both counters clear and all frames, plus the shadow directory, become invalid. The seen flags are kept.
- R10: After reset, `rsp_valid` and `low_req` are low, both counters are zero, and `acc_ready` goes high two cycles after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ways | input | 2 | Associativity code: ways = 2^code |
| cfg_wb | input | 1 | 1 = write-back, 0 = write-through |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_addr | input | 6 | Block address |
| acc_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Result of the access accepted in the previous cycle |
| rsp_hit | output | 1 | Hit flag |
| rsp_kind | output | 2 | 0 hit, 1 compulsory, 2 capacity, 3 conflict |
| low_req | output | 1 | One-cycle write request toward the lower level |
| low_req_addr | output | 6 | Block address of the request |
| low_req_evict | output | 1 | 1 = dirty eviction, 0 = write-through |
| cnt_access | output | 16 | Saturating count of accepted accesses |
| cnt_hit | output | 16 | Saturating count of hits |

## Verification
The bench builds the block with its default parameters: eight frames, a 64-block address space and 16-bit counters. With these values all four geometries can be reached through `cfg_ways`. It also lets the bench drive every address, so the seen flags and the capacity/conflict split can be followed exactly. The 16-bit counters can be driven to saturation in about 65 thousand accesses, which the bench does to check that they hold at all ones.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

  typedef enum logic [1:0] {
    KIND_NONE       = 2'd0,
    KIND_COMPULSORY = 2'd1,
    KIND_CAPACITY   = 2'd2,
    KIND_CONFLICT   = 2'd3
  } miss_kind_e;

endpackage

// File: rtl/ctd_sat_counter.sv
module ctd_sat_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & ~&cnt_q);
    cnt_d  = clr ? '0 : cnt_q + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/ctd_seen_bits.sv
module ctd_seen_bits #(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark,
  input  logic [ADDR_W-1:0] addr,
  output logic              seen
);

  logic [DEPTH-1:0] seen_q, seen_d;

  always_comb begin
    seen_d       = seen_q;
    seen_d[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen_q <= '0;
    else if (mark) seen_q <= seen_d;
  end

  assign seen = seen_q[addr];

endmodule

// File: rtl/ctd_frame_array.sv
module ctd_frame_array #(
  parameter int NUM_FRAMES = 8,
  parameter int ADDR_W     = 6,
  localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_dirty,
  input  logic [IDX_W-1:0]  set_mask,
  input  logic [IDX_W-1:0]  ways_m1,
  output logic              hit,
  output logic              evict,
  output logic              evict_dirty,
  output logic [ADDR_W-1:0] evict_addr
);

  logic [NUM_FRAMES-1:0] vld_q, vld_d, dty_q, dty_d;
  logic [ADDR_W-1:0]     tag_q [NUM_FRAMES];
  logic [ADDR_W-1:0]     tag_d [NUM_FRAMES];
  logic [IDX_W-1:0]      age_q [NUM_FRAMES];
  logic [IDX_W-1:0]      age_d [NUM_FRAMES];

  logic [NUM_FRAMES-1:0] in_set, hit_vec, free_vec, oldest_vec;
  logic [IDX_W-1:0]      hit_idx, free_idx, oldest_idx, touch_idx, touch_age;
  logic                  any_free, upd_en;

  // frame f belongs to set (f & mask); an address to set (addr & mask)
  always_comb begin
    for (int f = 0; f < NUM_FRAMES; f++) begin
      in_set[f]     = ((IDX_W'(f) ^ addr[IDX_W-1:0]) & set_mask) == '0;
      hit_vec[f]    = vld_q[f] & in_set[f] & (tag_q[f] == addr);
      free_vec[f]   = ~vld_q[f] & in_set[f];
      oldest_vec[f] = vld_q[f] & in_set[f] & (age_q[f] == ways_m1);
    end
  end

  // lowest-numbered candidate wins
  always_comb begin
    hit_idx    = '0;
    free_idx   = '0;
    oldest_idx = '0;
    for (int f = NUM_FRAMES - 1; f >= 0; f--) begin
      if (hit_vec[f])    hit_idx    = IDX_W'(f);
      if (free_vec[f])   free_idx   = IDX_W'(f);
      if (oldest_vec[f]) oldest_idx = IDX_W'(f);
    end
  end

  always_comb begin
    hit         = |hit_vec;
    any_free    = |free_vec;
    evict       = ~hit & ~any_free;
    evict_dirty = dty_q[oldest_idx];
    evict_addr  = tag_q[oldest_idx];
    touch_idx   = hit ? hit_idx : (any_free ? free_idx : oldest_idx);
    // a fresh fill ranks behind every valid frame of its set
    touch_age   = (hit | ~any_free) ? age_q[touch_idx] : IDX_W'(NUM_FRAMES - 1);
  end

  always_comb begin
    vld_d  = vld_q;
    dty_d  = dty_q;
    tag_d  = tag_q;
    age_d  = age_q;
    upd_en = clr | acc;
    if (clr) begin
      vld_d = '0;
      dty_d = '0;
      for (int f = 0; f < NUM_FRAMES; f++) age_d[f] = '0;
    end else if (acc) begin
      for (int f = 0; f < NUM_FRAMES; f++) begin
        if (in_set[f] && vld_q[f] && (age_q[f] < touch_age))
          age_d[f] = age_q[f] + IDX_W'(1);
      end
      vld_d[touch_idx] = 1'b1;
      tag_d[touch_idx] = addr;
      age_d[touch_idx] = '0;
      dty_d[touch_idx] = hit ? (dty_q[touch_idx] | wr_dirty) : wr_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      for (int f = 0; f < NUM_FRAMES; f++) begin
        tag_q[f] <= '0;
        age_q[f] <= '0;
      end
    end else if (upd_en) begin
      vld_q <= vld_d;
      dty_q <= dty_d;
      for (int f = 0; f < NUM_FRAMES; f++) begin
        tag_q[f] <= tag_d[f];
        age_q[f] <= age_d[f];
      end
    end
  end

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int NUM_FRAMES = 8,
  parameter int ADDR_W     = 6,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = $clog2(NUM_FRAMES),
  localparam int CFG_W     = $clog2(IDX_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_ways,
  input  logic              cfg_wb,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_kind,
  output logic              low_req,
  output logic [ADDR_W-1:0] low_req_addr,
  output logic              low_req_evict,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_hit
);
  import ctd_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // configuration tracking
  logic [CFG_W:0] cfg_q, cfg_now;
  logic           cfg_chg, hs;

  assign cfg_now = {cfg_ways, cfg_wb};
  assign cfg_chg = cfg_now != cfg_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  cfg_q <= '0;
    else if (cfg_chg) cfg_q <= cfg_now;
  end

  assign acc_ready = core_rst_n & ~cfg_chg;
  assign hs        = acc_valid & acc_ready;

  logic [IDX_W-1:0] set_mask, ways_m1;
  always_comb begin
    set_mask = IDX_W'((NUM_FRAMES >> cfg_ways) - 1);
    ways_m1  = IDX_W'((1 << cfg_ways) - 1);
  end

  // main directory
  logic              m_hit, m_evict, m_evict_dirty;
  logic [ADDR_W-1:0] m_evict_addr;

  ctd_frame_array #(.NUM_FRAMES(NUM_FRAMES), .ADDR_W(ADDR_W)) u_main (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .clr         (cfg_chg),
    .acc         (hs),
    .addr        (acc_addr),
    .wr_dirty    (acc_write & cfg_wb),
    .set_mask    (set_mask),
    .ways_m1     (ways_m1),
    .hit         (m_hit),
    .evict       (m_evict),
    .evict_dirty (m_evict_dirty),
    .evict_addr  (m_evict_addr)
  );

  // shadow fully associative directory for miss classification
  logic              sh_hit, sh_unused_evict, sh_unused_dirty;
  logic [ADDR_W-1:0] sh_unused_addr;

  ctd_frame_array #(.NUM_FRAMES(NUM_FRAMES), .ADDR_W(ADDR_W)) u_shadow (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .clr         (cfg_chg),
    .acc         (hs),
    .addr        (acc_addr),
    .wr_dirty    (1'b0),
    .set_mask    ('0),
    .ways_m1     (IDX_W'(NUM_FRAMES - 1)),
    .hit         (sh_hit),
    .evict       (sh_unused_evict),
    .evict_dirty (sh_unused_dirty),
    .evict_addr  (sh_unused_addr)
  );

  logic seen;
  ctd_seen_bits #(.ADDR_W(ADDR_W)) u_seen (
    .clk   (clk),
    .rst_n (core_rst_n),
    .mark  (hs),
    .addr  (acc_addr),
    .seen  (seen)
  );

  ctd_sat_counter #(.WIDTH(CNT_W)) u_cnt_acc (
    .clk (clk), .rst_n (core_rst_n), .clr (cfg_chg), .inc (hs), .count (cnt_access)
  );

  ctd_sat_counter #(.WIDTH(CNT_W)) u_cnt_hit (
    .clk (clk), .rst_n (core_rst_n), .clr (cfg_chg), .inc (hs & m_hit), .count (cnt_hit)
  );

  // response next-state
  miss_kind_e        kind_d;
  logic              req_d;
  logic [ADDR_W-1:0] req_addr_d;

  always_comb begin
    if (m_hit)        kind_d = KIND_NONE;
    else if (!seen)   kind_d = KIND_COMPULSORY;
    else if (!sh_hit) kind_d = KIND_CAPACITY;
    else              kind_d = KIND_CONFLICT;
    if (cfg_wb) begin
      req_d      = m_evict & m_evict_dirty;
      req_addr_d = m_evict_addr;
    end else begin
      req_d      = acc_write;
      req_addr_d = acc_addr;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rsp_valid <= 1'b0;
      low_req   <= 1'b0;
    end else begin
      rsp_valid <= hs;
      low_req   <= hs & req_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rsp_hit       <= 1'b0;
      rsp_kind      <= KIND_NONE;
      low_req_addr  <= '0;
      low_req_evict <= 1'b0;
    end else if (hs) begin
      rsp_hit       <= m_hit;
      rsp_kind      <= kind_d;
      low_req_addr  <= req_addr_d;
      low_req_evict <= cfg_wb;
    end
  end

endmodule

// File: rtl/ctd_checker.sv
module ctd_checker #(
  parameter int CFG_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_ways,
  input logic             cfg_wb,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic             acc_write,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [1:0]       rsp_kind,
  input logic             low_req,
  input logic             low_req_evict,
  input logic [CNT_W-1:0] cnt_access,
  input logic [CNT_W-1:0] cnt_hit
);

  p_rsp_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> rsp_valid);

  p_no_rsp_without_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_ready) |=> !rsp_valid);

  p_hit_kind_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_kind == 2'd0));

  p_miss_kind_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_kind != 2'd0));

  p_evict_only_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_req && low_req_evict) |-> ($past(cfg_wb) && rsp_valid && !rsp_hit));

  p_wt_req_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (low_req && !low_req_evict) |-> ($past(acc_write) && !$past(cfg_wb) && rsp_valid));

  p_hits_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit <= cnt_access);

  p_acc_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt_access) && acc_ready) |=> (&cnt_access));

  p_cfg_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({cfg_ways, cfg_wb} != $past({cfg_ways, cfg_wb})) |-> !acc_ready);

  p_cfg_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({cfg_ways, cfg_wb} != $past({cfg_ways, cfg_wb})) |=> (cnt_access == '0 && cnt_hit == '0));

endmodule

bind cache_tag_dir ctd_checker #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_cache_tag_dir.sv
`timescale 1ns/1ps
module tb_cache_tag_dir;

  logic       clk, rst_n;
  logic [1:0] cfg_ways;
  logic       cfg_wb, acc_valid, acc_ready, acc_write;
  logic [5:0] acc_addr, low_req_addr;
  logic       rsp_valid, rsp_hit, low_req, low_req_evict;
  logic [1:0] rsp_kind;
  logic [15:0] cnt_access, cnt_hit;

  cache_tag_dir dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, failures = 0;

  typedef struct packed {
    logic       hit;
    logic [1:0] kind;
    logic       req;
    logic [5:0] raddr;
    logic       evict;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model: MRU-ordered lists ----------------
  int m_ways;
  bit m_wb;
  int m_lst[8][8];
  int m_cnt[8];
  bit m_dty[64];
  bit m_seen[64];
  int sh_lst[8];
  int sh_cnt;
  int m_hits;

  function automatic void model_clear();
    for (int s = 0; s < 8; s++) m_cnt[s] = 0;
    for (int a = 0; a < 64; a++) m_dty[a] = 1'b0;
    sh_cnt = 0;
    m_hits = 0;
  endfunction

  function automatic exp_t model_access(int a, bit w);
    exp_t e;
    int pos, sets, s, v;
    bit shit;
    e = '0;
    pos = -1;
    for (int i = 0; i < sh_cnt; i++) if (sh_lst[i] == a) pos = i;
    shit = (pos >= 0);
    if (!shit) begin
      if (sh_cnt < 8) sh_cnt++;
      pos = sh_cnt - 1;
    end
    for (int i = pos; i > 0; i--) sh_lst[i] = sh_lst[i-1];
    sh_lst[0] = a;

    sets = 8 / m_ways;
    s = a % sets;
    pos = -1;
    for (int i = 0; i < m_cnt[s]; i++) if (m_lst[s][i] == a) pos = i;
    e.hit = (pos >= 0);
    if (e.hit) begin
      m_hits++;
      if (w && m_wb) m_dty[a] = 1'b1;
    end else begin
      if (m_cnt[s] == m_ways) begin
        v = m_lst[s][m_ways-1];
        if (m_wb && m_dty[v]) begin
          e.req = 1'b1; e.raddr = 6'(v); e.evict = 1'b1;
        end
        m_dty[v] = 1'b0;
        pos = m_ways - 1;
      end else begin
        m_cnt[s]++;
        pos = m_cnt[s] - 1;
      end
      m_dty[a] = w && m_wb;
    end
    for (int i = pos; i > 0; i--) m_lst[s][i] = m_lst[s][i-1];
    m_lst[s][0] = a;
    if (!m_wb && w) begin
      e.req = 1'b1; e.raddr = 6'(a); e.evict = 1'b0;
    end
    if (e.hit)            e.kind = 2'd0;
    else if (!m_seen[a])  e.kind = 2'd1;
    else if (!shit)       e.kind = 2'd2;
    else                  e.kind = 2'd3;
    m_seen[a] = 1'b1;
    return e;
  endfunction

  // ---------------- driver ----------------
  task automatic access(int a, bit w, string tag);
    @(negedge clk);
    if (!acc_ready) begin
      checks++; failures++;
      $display("FAIL R3 acc_ready actual=0 expected=1");
    end
    acc_valid = 1'b1;
    acc_addr  = 6'(a);
    acc_write = w;
    q_exp.push_back(model_access(a, w));
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
  endtask

  task automatic set_cfg(int code, bit wb);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_ways  = 2'(code);
    cfg_wb    = wb;
    #1;
    chk("R9", "acc_ready during change", int'(acc_ready), 0);
    m_ways = 1 << code;
    m_wb   = wb;
    model_clear();
    @(negedge clk);
    chk("R9", "cnt_access cleared", int'(cnt_access), 0);
    chk("R9", "cnt_hit cleared", int'(cnt_hit), 0);
    chk("R9", "acc_ready after change", int'(acc_ready), 1);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_exp.size() == 0) begin
        checks++; failures++;
        $display("FAIL R3 unexpected rsp_valid actual=1 expected=0");
      end else begin
        exp_t e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, "rsp_hit", int'(rsp_hit), int'(e.hit));
        chk(t, "rsp_kind", int'(rsp_kind), int'(e.kind));
        chk(t, "low_req", int'(low_req), int'(e.req));
        if (e.req) begin
          chk(t, "low_req_addr", int'(low_req_addr), int'(e.raddr));
          chk(t, "low_req_evict", int'(low_req_evict), int'(e.evict));
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int seq[22] = '{0,0,8,8,16,16,24,32,40,44,0,8,16,24,1,2,3,4,1,2,3,4};

  task automatic run_seq(string tag, int exp_hits);
    for (int i = 0; i < 22; i++) access(seq[i], 1'b0, tag);
    idle();
    chk(tag, "cnt_access after sequence", int'(cnt_access), 22);
    chk(tag, "cnt_hit after sequence", int'(cnt_hit), exp_hits);
    chk(tag, "model hits", m_hits, exp_hits);
  endtask

  initial begin
    rst_n = 1'b0; cfg_ways = 2'd0; cfg_wb = 1'b0;
    acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0;
    m_ways = 1; m_wb = 1'b0; sh_cnt = 0; m_hits = 0;
    for (int a = 0; a < 64; a++) m_seen[a] = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R10", "acc_ready in reset", int'(acc_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "acc_ready", int'(acc_ready), 1);
    chk("R10", "rsp_valid", int'(rsp_valid), 0);
    chk("R10", "low_req", int'(low_req), 0);
    chk("R10", "cnt_access", int'(cnt_access), 0);
    chk("R10", "cnt_hit", int'(cnt_hit), 0);

    // R1, R3, R4: direct-mapped sequence, back-to-back accesses
    run_seq("R1", 7);
    // R5: conflict in direct-mapped (shadow still holds 8)
    access(0, 1'b0, "R5"); access(8, 1'b0, "R5"); access(0, 1'b0, "R5");
    // R7: write-through requests on writes, none on eviction
    access(3, 1'b1, "R7"); access(11, 1'b0, "R7"); access(11, 1'b1, "R7");
    idle();

    set_cfg(1, 1'b0);
    run_seq("R1", 7);
    // R2: LRU inside a 2-way set (set 0 = addresses 0,4,8 mod 4)
    access(0, 1'b0, "R2"); access(4, 1'b0, "R2"); access(0, 1'b0, "R2");
    access(8, 1'b0, "R2"); access(0, 1'b0, "R2"); access(4, 1'b0, "R2");
    idle();

    set_cfg(2, 1'b0);
    run_seq("R1", 7);

    set_cfg(3, 1'b0);
    run_seq("R1", 11);
    // R5: capacity misses with nine distinct blocks cycled
    for (int i = 0; i < 9; i++) access(i + 20, 1'b0, "R5");
    access(20, 1'b0, "R5");
    idle();

    // R6: write-back in direct-mapped mode
    set_cfg(0, 1'b1);
    access(0, 1'b1, "R6"); access(8, 1'b0, "R6"); access(16, 1'b0, "R6");
    access(1, 1'b0, "R6"); access(1, 1'b1, "R6"); access(9, 1'b1, "R6");
    access(17, 1'b0, "R6");
    idle();
    // R6: write-back in fully associative mode
    set_cfg(3, 1'b1);
    for (int i = 0; i < 8; i++) access(i + 30, i[0], "R6");
    for (int i = 0; i < 4; i++) access(i + 50, 1'b0, "R6");
    idle();

    // R9: policy change alone invalidates frames
    set_cfg(0, 1'b0);
    access(5, 1'b0, "R9"); access(5, 1'b0, "R9");
    idle();
    set_cfg(0, 1'b1);
    access(5, 1'b0, "R9");
    idle();

    // R8: counter saturation
    set_cfg(3, 1'b0);
    for (int i = 0; i < 65540; i++) access(0, 1'b0, "R8");
    idle();
    chk("R8", "cnt_access saturated", int'(cnt_access), 65535);
    chk("R8", "cnt_hit saturated", int'(cnt_hit), 65535);

    @(negedge clk);
    chk("R3", "pending responses", q_exp.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule